// File: doc/BRIEF.md
# Wiper Save and Recall Sequencer

This block sits between a volatile wiper code register and a byte-wide nonvolatile store. It orders every transfer between the two. When reset is released, it first forces the wiper to the midpoint code. It then spends a power-up window fetching the saved byte and loads it into the wiper. After that it waits for commands. A save command copies the current wiper code into the store. A recall command reloads the wiper from the store.

Each operation holds `busy` high for a fixed number of clock cycles. The operation durations and the minimum spacing between two writes to the store are parameters, counted in clock cycles. A protect input blocks saves but still allows recalls. A request that cannot be accepted has no effect on the block. Instead it raises a one-cycle `err` pulse.

The wiper owner copies `wiper_val` whenever `wiper_ld` is high. The store is read combinationally through `nv_addr`/`nv_rdata`. It is written by a single-cycle `nv_we` strobe.

Top module: `nvw_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`=1, `wiper_ld`=1 and `wiper_val`=0x20 (the midpoint of the 6-bit code). In the same cycles `nv_we`=0 and `err`=0.
- R2: After the preset cycle, `busy` stays high for exactly T_PUP cycles. Only in the last of these cycles, `wiper_ld`=1 with `wiper_val` equal to bits [5:0] of the byte at address WIPER_SLOT. `busy` then falls.
- R3: A `restore_req` sampled while idle makes `busy` high for exactly T_RESTORE cycles, starting in the next cycle. `wiper_ld` pulses only in the last of these cycles, with `wiper_val` = `nv_rdata[5:0]`.
- R4: A `store_req` sampled while idle, with `wr_protect`=0 and the rewrite gap elapsed, has these effects:
  - `nv_we` is high for exactly the first busy cycle.
  - In that cycle, `nv_wdata` = {2'b00, the `wiper_code` sampled with the request} and `nv_addr` = WIPER_SLOT.
  - `busy` lasts T_STORE cycles, and `wiper_ld` stays 0 throughout.
- R5: A `store_req` sampled with `wr_protect`=1 produces no write and leaves `busy` low. It pulses `err` in the next cycle, and the stored byte is unchanged.
- R6: A request sampled while `busy` is high is ignored: no write, no extra load, and no change to the window length. It pulses `err` in the next cycle.
- R7: If both requests are sampled together while idle, the recall is performed and the save is dropped, with an `err` pulse.
- R8: A save is accepted only if at least T_GAP cycles separate its sampling edge from that of the previous accepted save. An earlier save request is dropped with an `err` pulse even though `busy` is low.

Widths: `wiper_code` and `wiper_val` are CODE_W bits, `nv_addr` is ADDR_W bits, and `nv_rdata`/`nv_wdata` are DATA_W bits. The defaults are 6, 5 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| store_req | input | 1 | Request to save the wiper code |
| restore_req | input | 1 | Request to reload the wiper from the store |
| wiper_code | input | CODE_W | Current wiper code |
| wr_protect | input | 1 | Blocks saves when high |
| nv_rdata | input | DATA_W | Byte read from the store at `nv_addr` |
| wiper_ld | output | 1 | Wiper load strobe |
| wiper_val | output | CODE_W | Value to load into the wiper |
| nv_we | output | 1 | Store write strobe |
| nv_addr | output | ADDR_W | Store address of the wiper slot |
| nv_wdata | output | DATA_W | Byte to write into the store |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-cycle pulse for a dropped request |

## Verification
The hardest case to reach from the ports is the rewrite gap. It is hidden behind the save window, so a save request can be rejected while `busy` is already low. The bench therefore uses a gap longer than the save window plus one. It fires a save right after the previous one finishes, expecting a rejection. It then retries on the exact first edge the gap allows. The exhaustive sweep saves every code and recalls it in between, which also lands each next save on that boundary edge.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

   typedef enum logic [2:0] {
      NVW_PRESET  = 3'd0,
      NVW_BOOT    = 3'd1,
      NVW_IDLE    = 3'd2,
      NVW_SAVE    = 3'd3,
      NVW_RECALL  = 3'd4
   } nvw_state_e;

   function automatic int nvw_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int nvw_cnt_bits(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/nvw_down_timer.sv
module nvw_down_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nvw_req_arbiter.sv
module nvw_req_arbiter (
   input  logic idle,
   input  logic store_req,
   input  logic restore_req,
   input  logic wr_protect,
   input  logic gap_clear,
   output logic recall_go,
   output logic save_go,
   output logic drop
);

   logic save_ok;

   always_comb begin
      recall_go = idle & restore_req;
      save_ok   = idle & ~restore_req & ~wr_protect & gap_clear;
      save_go   = store_req & save_ok;
      drop      = (restore_req & ~idle) | (store_req & ~save_ok);
   end

endmodule

// File: rtl/nvw_sequencer.sv
module nvw_sequencer #(
   parameter int CODE_W     = 6,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 5,
   parameter int WIPER_SLOT = 0,
   parameter int T_PUP      = 15000,
   parameter int T_RESTORE  = 15000,
   parameter int T_STORE    = 1300000,
   parameter int T_GAP      = 27000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_req,
   input  logic              restore_req,
   input  logic [CODE_W-1:0] wiper_code,
   input  logic              wr_protect,
   input  logic [DATA_W-1:0] nv_rdata,
   output logic              wiper_ld,
   output logic [CODE_W-1:0] wiper_val,
   output logic              nv_we,
   output logic [ADDR_W-1:0] nv_addr,
   output logic [DATA_W-1:0] nv_wdata,
   output logic              busy,
   output logic              err
);
   import nvw_pkg::*;

   localparam int MAX_T = nvw_max(nvw_max(T_PUP, T_RESTORE), T_STORE);
   localparam int CNT_W = nvw_cnt_bits(MAX_T);
   localparam int GAP_W = nvw_cnt_bits(T_GAP);
   localparam logic [CNT_W-1:0]  PUP_LD = CNT_W'(T_PUP - 1);
   localparam logic [CNT_W-1:0]  RCL_LD = CNT_W'(T_RESTORE - 1);
   localparam logic [CNT_W-1:0]  SAV_LD = CNT_W'(T_STORE - 1);
   localparam logic [CODE_W-1:0] MID    = CODE_W'(1) << (CODE_W - 1);
   localparam logic [ADDR_W-1:0] SLOT   = ADDR_W'(WIPER_SLOT);

   initial begin
      assert (CODE_W >= 1 && CODE_W <= DATA_W) else $error("CODE_W must fit in DATA_W");
      assert (T_PUP >= 1 && T_RESTORE >= 1 && T_STORE >= 1) else $error("durations must be at least 1");
      assert (T_GAP >= 1) else $error("T_GAP must be at least 1");
      assert (WIPER_SLOT >= 0 && WIPER_SLOT < (1 << ADDR_W)) else $error("WIPER_SLOT out of range");
   end

   nvw_state_e       state_q, state_d;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             gap_clear;
   logic             recall_go, save_go, drop;
   logic             we_q, err_q;
   logic [DATA_W-1:0] wdata_q;

   nvw_req_arbiter u_arb (
      .idle        (state_q == NVW_IDLE),
      .store_req   (store_req),
      .restore_req (restore_req),
      .wr_protect  (wr_protect),
      .gap_clear   (gap_clear),
      .recall_go   (recall_go),
      .save_go     (save_go),
      .drop        (drop)
   );

   always_comb begin
      tmr_load = (state_q == NVW_PRESET) | recall_go | save_go;
      if (state_q == NVW_PRESET)
         tmr_val = PUP_LD;
      else if (recall_go)
         tmr_val = RCL_LD;
      else
         tmr_val = SAV_LD;
   end

   nvw_down_timer #(.CNT_W(CNT_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero_o   (tmr_zero)
   );

   generate
      if (T_GAP > T_STORE + 1) begin : g_gap
         nvw_down_timer #(.CNT_W(GAP_W)) u_gap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (save_go),
            .load_val (GAP_W'(T_GAP - 1)),
            .zero_o   (gap_clear)
         );

         // R8
         gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gap_clear && store_req && !busy) |=> (err && !nv_we && !busy))
            else $error("save accepted inside rewrite gap");
      end else begin : g_nogap
         assign gap_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      case (state_q)
         NVW_PRESET: state_d = NVW_BOOT;
         NVW_BOOT:   if (tmr_zero) state_d = NVW_IDLE;
         NVW_IDLE: begin
            if (recall_go)    state_d = NVW_RECALL;
            else if (save_go) state_d = NVW_SAVE;
         end
         NVW_SAVE:   if (tmr_zero) state_d = NVW_IDLE;
         NVW_RECALL: if (tmr_zero) state_d = NVW_IDLE;
         default:    state_d = NVW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= NVW_PRESET;
         we_q    <= 1'b0;
         err_q   <= 1'b0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         we_q    <= save_go;
         err_q   <= drop;
         if (save_go)
            wdata_q <= DATA_W'(wiper_code);
      end
   end

   assign busy      = (state_q != NVW_IDLE);
   assign wiper_ld  = (state_q == NVW_PRESET) |
                      (((state_q == NVW_BOOT) | (state_q == NVW_RECALL)) & tmr_zero);
   assign wiper_val = (state_q == NVW_PRESET) ? MID : nv_rdata[CODE_W-1:0];
   assign nv_we     = we_q;
   assign nv_addr   = SLOT;
   assign nv_wdata  = wdata_q;
   assign err       = err_q;

   // R4
   save_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && store_req && !restore_req && !wr_protect && gap_clear) |=> (nv_we && busy))
      else $error("accepted save did not write");

   // R4
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_we |=> !nv_we)
      else $error("write strobe longer than one cycle");

   // R5
   protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && store_req && !restore_req && wr_protect) |=> (!nv_we && !busy && err))
      else $error("protected save not blocked");

   // R6
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (store_req || restore_req)) |=> (err && !nv_we))
      else $error("request during busy not dropped");

   // R7
   both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && store_req && restore_req) |=> (busy && err && !nv_we))
      else $error("recall did not win over save");

   // R3
   ld_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_ld && state_q != NVW_PRESET) |=> !busy)
      else $error("load strobe not in last busy cycle");

endmodule

// File: tb/test_nvw_sequencer.sv
module test_nvw_sequencer;
   localparam int CLK_P   = 10;
   localparam int CODE_W  = 6;
   localparam int DATA_W  = 8;
   localparam int ADDR_W  = 5;
   localparam int SLOT    = 5;
   localparam int TP      = 5;
   localparam int TR      = 3;
   localparam int TS      = 7;
   localparam int TG      = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              store_req = 1'b0;
   logic              restore_req = 1'b0;
   logic [CODE_W-1:0] wiper_code = '0;
   logic              wr_protect = 1'b0;
   logic [DATA_W-1:0] nv_rdata;
   logic              wiper_ld;
   logic [CODE_W-1:0] wiper_val;
   logic              nv_we;
   logic [ADDR_W-1:0] nv_addr;
   logic [DATA_W-1:0] nv_wdata;
   logic              busy;
   logic              err;

   logic [DATA_W-1:0] mem [32];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mem[i] <= DATA_W'(i * 37 + 11);
         mem[SLOT] <= 8'hC7;
      end else if (nv_we) begin
         mem[nv_addr] <= nv_wdata;
      end
   end
   assign nv_rdata = mem[nv_addr];

   nvw_sequencer #(
      .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIPER_SLOT(SLOT),
      .T_PUP(TP), .T_RESTORE(TR), .T_STORE(TS), .T_GAP(TG)
   ) i_nvw_sequencer (
      .clk(clk), .rst_n(rst_n), .store_req(store_req), .restore_req(restore_req),
      .wiper_code(wiper_code), .wr_protect(wr_protect), .nv_rdata(nv_rdata),
      .wiper_ld(wiper_ld), .wiper_val(wiper_val), .nv_we(nv_we), .nv_addr(nv_addr),
      .nv_wdata(nv_wdata), .busy(busy), .err(err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_restore(input int exp, input bit inject);
      restore_req = 1'b1;
      for (int k = 0; k < TR; k++) begin
         @(negedge clk);
         if (k == 0) begin
            restore_req = 1'b0;
            if (inject) store_req = 1'b1;
         end
         if (k == 1 && inject) begin
            store_req = 1'b0;
            chk(err == 1'b1, "R6 err", int'(err), 1);
            chk(nv_we == 1'b0, "R6 no write", int'(nv_we), 0);
         end
         chk(busy == 1'b1, "R3 busy", int'(busy), 1);
         chk(wiper_ld == (k == TR - 1), "R3 ld", int'(wiper_ld), int'(k == TR - 1));
         if (k == TR - 1) chk(int'(wiper_val) == exp, "R3 value", int'(wiper_val), exp);
      end
      @(negedge clk);
      chk(busy == 1'b0, "R3 end", int'(busy), 0);
   endtask

   task automatic do_store(input int code, input bit inject);
      store_req  = 1'b1;
      wiper_code = CODE_W'(code);
      for (int k = 0; k < TS; k++) begin
         @(negedge clk);
         if (k == 0) begin
            store_req  = 1'b0;
            wiper_code = ~CODE_W'(code);
            chk(nv_we == 1'b1, "R4 we", int'(nv_we), 1);
            chk(int'(nv_wdata) == code, "R4 wdata", int'(nv_wdata), code);
            chk(int'(nv_addr) == SLOT, "R4 addr", int'(nv_addr), SLOT);
            if (inject) restore_req = 1'b1;
         end else begin
            chk(nv_we == 1'b0, "R4 we single", int'(nv_we), 0);
         end
         if (k == 1 && inject) begin
            restore_req = 1'b0;
            chk(err == 1'b1, "R6 err in save", int'(err), 1);
         end
         chk(busy == 1'b1, "R4 busy", int'(busy), 1);
         chk(wiper_ld == 1'b0, "R4 no ld", int'(wiper_ld), 0);
      end
      @(negedge clk);
      chk(busy == 1'b0, "R4 end", int'(busy), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(busy == 1'b1, "R1 busy", int'(busy), 1);
      chk(wiper_ld == 1'b1, "R1 ld", int'(wiper_ld), 1);
      chk(int'(wiper_val) == 'h20, "R1 mid", int'(wiper_val), 'h20);
      chk(nv_we == 1'b0 && err == 1'b0, "R1 quiet", int'({nv_we, err}), 0);
      rst_n = 1'b1;
      #1;
      chk(wiper_ld == 1'b1 && int'(wiper_val) == 'h20, "R1 after release", int'(wiper_val), 'h20);
      // R2 power-up window
      for (int k = 0; k < TP; k++) begin
         @(negedge clk);
         chk(busy == 1'b1, "R2 busy", int'(busy), 1);
         chk(wiper_ld == (k == TP - 1), "R2 ld", int'(wiper_ld), int'(k == TP - 1));
         if (k == TP - 1) chk(int'(wiper_val) == 'h07, "R2 value", int'(wiper_val), 'h07);
      end
      @(negedge clk);
      chk(busy == 1'b0, "R2 end", int'(busy), 0);

      // exhaustive save/recall sweep; each next save lands on the R8 boundary edge
      for (int c = 0; c < 64; c++) begin
         do_store(c, 1'b0);
         do_restore(c, 1'b0);
      end

      // R5 protected save
      wr_protect = 1'b1;
      store_req  = 1'b1;
      wiper_code = 6'h11;
      @(negedge clk);
      store_req = 1'b0;
      chk(nv_we == 1'b0, "R5 no write", int'(nv_we), 0);
      chk(busy == 1'b0, "R5 not busy", int'(busy), 0);
      chk(err == 1'b1, "R5 err", int'(err), 1);
      @(negedge clk);
      chk(err == 1'b0, "R5 err single", int'(err), 0);
      do_restore(63, 1'b0);
      wr_protect = 1'b0;

      // R7 simultaneous requests
      store_req   = 1'b1;
      restore_req = 1'b1;
      wiper_code  = 6'h2B;
      for (int k = 0; k < TR; k++) begin
         @(negedge clk);
         store_req   = 1'b0;
         restore_req = 1'b0;
         if (k == 0) begin
            chk(err == 1'b1, "R7 err", int'(err), 1);
            chk(nv_we == 1'b0, "R7 no write", int'(nv_we), 0);
         end
         chk(busy == 1'b1, "R7 busy", int'(busy), 1);
         if (k == TR - 1) chk(wiper_ld && int'(wiper_val) == 63, "R7 recall value", int'(wiper_val), 63);
      end
      @(negedge clk);
      chk(busy == 1'b0, "R7 end", int'(busy), 0);

      // R6 requests during busy windows
      do_restore(63, 1'b1);
      do_store(6'h15, 1'b1);

      // R8 early save rejected, boundary save accepted
      store_req  = 1'b1;
      wiper_code = 6'h3C;
      @(negedge clk);
      store_req = 1'b0;
      chk(err == 1'b1, "R8 err", int'(err), 1);
      chk(nv_we == 1'b0, "R8 no write", int'(nv_we), 0);
      chk(busy == 1'b0, "R8 not busy", int'(busy), 0);
      repeat (3) @(negedge clk);
      do_store(6'h2A, 1'b0);
      do_restore(6'h2A, 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule